// File: doc/BRIEF.md
# Key Event Recorder with Live Duration

This block keeps a short history of key and jack events in a small circular store. Each event arrives as a one-cycle strobe carrying an already classified key code. The block writes that code into a fresh entry and clears the entry's duration. From then on, every slow tick adds one to the duration of that newest entry. The newest entry is the one "in progress". It stays open, and its duration keeps growing in place, until the next event closes it and opens another.

A host interface reads entries one at a time. The entry at the read position is always visible on the output pins. A read-advance pulse removes that entry only if it is closed. When no closed entry is waiting, the output shows the in-progress entry with its current duration, and a read leaves it in place. An active-low interrupt falls when an event is recorded and rises again after the host reads. An empty flag tells the host whether any closed entries remain. If closed entries fill all but one slot, the next event drops the oldest closed entry. A synchronous clear returns every entry to its idle contents.

The event, tick, read and clear inputs are plain strobes. There is no back-pressure: every event is taken in the cycle it is strobed, because the overwrite policy makes room when the store is full. The read output behaves like a stream head that is always valid. `rd_adv` acts as the ready pulse that pops one closed entry.

Top module: `key_event_fifo`

## Requirements
- R1: After reset, every entry holds key 0xFF and duration 0x00, `empty` is 1, `irq_n` is 1, and the read outputs show 0xFF / 0x00.
- R2: An event writes its key code and a duration of 0x00 into a new entry. The first event after reset or clear opens slot 0 and closes nothing. Every later event closes the entry in progress and opens the next slot, wrapping modulo DEPTH.
- R3: A tick adds one to the 7-bit count (bits 6:0 of the duration byte) of the entry in progress. The read outputs show the new count from the cycle after the tick. A tick has no effect while no entry has been opened since reset or clear.
- R4: A tick on a count of 127 gives a count of 0 and sets the overflow bit (bit 7 of the duration byte). The overflow bit then stays 1 through further ticks until that entry is rewritten or cleared.
- R5: An event in the same cycle as a tick wins: the new entry starts at duration 0x00, and the tick is lost.
- R6: The read outputs show the oldest closed entry. `rd_adv` removes it and exposes the next one in the order the entries were recorded.
- R7: With no closed entry waiting, the read outputs show the entry in progress, and `rd_adv` changes neither the pointers nor `empty`.
- R8: When DEPTH-1 closed entries are waiting and an event arrives, the oldest closed entry is discarded. The number of closed entries stays at DEPTH-1.
- R9: `irq_n` is 0 in the cycle after an event. It is 1 in the cycle after `rd_adv` when no event is strobed in the same cycle (an event wins over a read in the same cycle).
- R10: `empty` is 1 exactly when no closed entry is waiting to be read.
- R11: `clr` has the same effect as reset (R1) and overrides any event, tick or read in the same cycle.
- R12: A read and an event in the same cycle are both applied: the read pops first, then the event records.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | One-cycle strobe: a new key or jack state is recorded |
| evt_key | input | 8 | Key code that comes with `evt_valid` |
| tick | input | 1 | Duration tick enable (one per 32 ms period) |
| rd_adv | input | 1 | Host read pulse: pops the shown entry if it is closed |
| clr | input | 1 | Synchronous clear to the idle state |
| rd_key | output | 8 | Key byte of the entry at the read position |
| rd_dur | output | 8 | Duration byte: bit 7 is overflow, bits 6:0 are the count |
| empty | output | 1 | No closed entry is waiting |
| irq_n | output | 1 | Active-low event interrupt |

## Verification
The bench builds the block with its default depth of eight entries, so the pointers wrap and the overwrite case is reached within a few dozen events. With a 7-bit count, a single in-progress entry reaches the count wrap and the sticky overflow bit in 128 ticks, which is why that width keeps the bench short. A long pseudo-random run then mixes events, ticks, reads and clears in every same-cycle combination. That run reaches the collisions of an event with a read, an event with a tick, and a read on an empty store, each many times at different fill levels.

// File: rtl/kef_pkg.sv
package kef_pkg;
  localparam int KEY_W = 8;
  localparam int CNT_W = 7;
  localparam int DUR_W = CNT_W + 1;

  typedef struct packed {
    logic [KEY_W-1:0] key;
    logic             ovf;
    logic [CNT_W-1:0] cnt;
  } kef_entry_t;

  localparam logic [KEY_W-1:0] IDLE_KEY = '1;

  function automatic kef_entry_t idle_entry();
    kef_entry_t e;
    e.key = IDLE_KEY;
    e.ovf = 1'b0;
    e.cnt = '0;
    return e;
  endfunction

  function automatic kef_entry_t tick_entry(kef_entry_t e);
    kef_entry_t n;
    n.key = e.key;
    n.cnt = e.cnt + 1'b1;
    n.ovf = e.ovf | (&e.cnt);
    return n;
  endfunction
endpackage

// File: rtl/kef_ptr.sv
module kef_ptr #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             evt,
  input  logic             rd,
  output logic [PTR_W-1:0] rd_idx,
  output logic [PTR_W-1:0] wr_idx,
  output logic             live,
  output logic             empty
);
  localparam logic [PTR_W-1:0] LAST_CNT = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] wp_q, rp_q, cnt_q;
  logic [PTR_W-1:0] rp_a, cnt_a;
  logic [PTR_W-1:0] wp_d, rp_d, cnt_d;
  logic             live_d, pop;

  assign pop    = rd && (cnt_q != '0);
  assign rp_a   = pop ? rp_q + 1'b1 : rp_q;
  assign cnt_a  = pop ? cnt_q - 1'b1 : cnt_q;
  assign wr_idx = (evt && live) ? wp_q + 1'b1 : wp_q;

  always_comb begin
    wp_d   = wp_q;
    rp_d   = rp_a;
    cnt_d  = cnt_a;
    live_d = live;
    if (evt) begin
      live_d = 1'b1;
      if (live) begin
        wp_d = wp_q + 1'b1;
        if (cnt_a == LAST_CNT) rp_d = rp_a + 1'b1;
        else                   cnt_d = cnt_a + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0; live <= 1'b0;
    end else if (clr) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0; live <= 1'b0;
    end else begin
      wp_q <= wp_d; rp_q <= rp_d; cnt_q <= cnt_d; live <= live_d;
    end
  end

  assign rd_idx = rp_q;
  assign empty  = (cnt_q == '0);
endmodule

// File: rtl/kef_store.sv
module kef_store
  import kef_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             evt,
  input  logic [KEY_W-1:0] evt_key,
  input  logic             tick_en,
  input  logic [PTR_W-1:0] wr_idx,
  input  logic [PTR_W-1:0] rd_idx,
  output kef_entry_t       rd_entry
);
  kef_entry_t slot_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic sel;
    assign sel = (wr_idx == PTR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            slot_q[i] <= idle_entry();
      else if (clr)          slot_q[i] <= idle_entry();
      else if (evt && sel)   slot_q[i] <= '{key: evt_key, ovf: 1'b0, cnt: '0};
      else if (tick_en && sel) slot_q[i] <= tick_entry(slot_q[i]);
    end
  end

  assign rd_entry = slot_q[rd_idx];
endmodule

// File: rtl/kef_irq.sv
module kef_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic evt,
  input  logic rd,
  output logic irq_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   irq_n <= 1'b1;
    else if (clr) irq_n <= 1'b1;
    else if (evt) irq_n <= 1'b0;
    else if (rd)  irq_n <= 1'b1;
  end
endmodule

// File: rtl/key_event_fifo.sv
module key_event_fifo
  import kef_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid,
  input  logic [KEY_W-1:0] evt_key,
  input  logic             tick,
  input  logic             rd_adv,
  input  logic             clr,
  output logic [KEY_W-1:0] rd_key,
  output logic [DUR_W-1:0] rd_dur,
  output logic             empty,
  output logic             irq_n
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [PTR_W-1:0] rd_idx, wr_idx;
  logic             live;
  kef_entry_t       head;

  kef_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clr(clr), .evt(evt_valid), .rd(rd_adv),
    .rd_idx(rd_idx), .wr_idx(wr_idx), .live(live), .empty(empty)
  );

  kef_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(clr), .evt(evt_valid), .evt_key(evt_key),
    .tick_en(tick && live), .wr_idx(wr_idx), .rd_idx(rd_idx), .rd_entry(head)
  );

  kef_irq u_irq (
    .clk(clk), .rst_n(rst_n), .clr(clr), .evt(evt_valid), .rd(rd_adv),
    .irq_n(irq_n)
  );

  assign rd_key = head.key;
  assign rd_dur = {head.ovf, head.cnt};
endmodule

// File: rtl/kef_checker.sv
module kef_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       evt_valid,
  input logic [7:0] evt_key,
  input logic       tick,
  input logic       rd_adv,
  input logic       clr,
  input logic [7:0] rd_key,
  input logic [7:0] rd_dur,
  input logic       empty,
  input logic       irq_n,
  input logic       live
);
  p_clear_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (empty && irq_n && rd_key == 8'hFF && rd_dur == 8'h00));

  p_irq_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !clr) |=> !irq_n);

  p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_adv && !evt_valid && !clr) |=> irq_n);

  p_empty_read_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_adv && !evt_valid && !clr) |=> (empty && $stable(rd_key)));

  p_tick_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (live && empty && tick && !evt_valid && !clr && rd_dur[6:0] != 7'h7F)
      |=> rd_dur == $past(rd_dur) + 8'd1);

  p_wrap_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (live && empty && tick && !evt_valid && !clr && rd_dur[6:0] == 7'h7F)
      |=> rd_dur == 8'h80);

  p_idle_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!live && tick && !evt_valid && !clr) |=> rd_dur == 8'h00);

  p_first_evt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !clr && !live) |=> (rd_key == $past(evt_key) && rd_dur == 8'h00 && empty));
endmodule

bind key_event_fifo kef_checker u_chk (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_key(evt_key),
  .tick(tick), .rd_adv(rd_adv), .clr(clr), .rd_key(rd_key), .rd_dur(rd_dur),
  .empty(empty), .irq_n(irq_n), .live(live)
);

// File: tb/key_event_fifo_test.sv
module key_event_fifo_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_valid = 1'b0, tick = 1'b0, rd_adv = 1'b0, clr = 1'b0;
  logic [7:0] evt_key = 8'h00;
  logic [7:0] rd_key, rd_dur;
  logic empty, irq_n;

  int compared = 0, mismatched = 0;
  int m_key [8];
  int m_dur [8];
  int m_wp, m_rp, m_cnt;
  bit m_live, m_irq;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  key_event_fifo uut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_key(evt_key),
    .tick(tick), .rd_adv(rd_adv), .clr(clr), .rd_key(rd_key), .rd_dur(rd_dur),
    .empty(empty), .irq_n(irq_n)
  );

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic m_idle();
    for (int i = 0; i < 8; i++) begin m_key[i] = 255; m_dur[i] = 0; end
    m_wp = 0; m_rp = 0; m_cnt = 0; m_live = 0; m_irq = 1;
  endtask

  task automatic compare_all(string tag);
    chk({tag, " R6 key"}, rd_key, m_key[m_rp]);
    chk({tag, " R3 dur"}, rd_dur, m_dur[m_rp]);
    chk({tag, " R10 empty"}, empty, (m_cnt == 0) ? 1 : 0);
    chk({tag, " R9 irq_n"}, irq_n, m_irq ? 1 : 0);
  endtask

  // Drive at negedge, let one posedge pass, update the model, compare at next negedge.
  task automatic cyc(bit e, int k, bit t, bit r, bit c, string tag);
    evt_valid = e; evt_key = k[7:0]; tick = t; rd_adv = r; clr = c;
    @(posedge clk);
    if (c) m_idle();
    else begin
      if (r && m_cnt > 0) begin m_rp = (m_rp + 1) % 8; m_cnt--; end
      if (e) begin
        if (m_live) begin
          m_wp = (m_wp + 1) % 8;
          if (m_cnt == 7) m_rp = (m_rp + 1) % 8; else m_cnt++;
        end
        m_live = 1; m_key[m_wp] = k; m_dur[m_wp] = 0; m_irq = 0;
      end else begin
        if (t && m_live) begin
          int c7;
          c7 = (m_dur[m_wp] % 128) + 1;
          if (c7 == 128) m_dur[m_wp] = 128;
          else m_dur[m_wp] = (m_dur[m_wp] / 128) * 128 + c7;
        end
        if (r) m_irq = 1;
      end
    end
    @(negedge clk);
    evt_valid = 0; tick = 0; rd_adv = 0; clr = 0;
    compare_all(tag);
  endtask

  initial begin
    #(20ns * 200000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    m_idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1 reset");

    // R3: ticks before any event do nothing
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 0, "R3 idle tick");
    // R2 first event, R7 reads of the live entry
    cyc(1, 8'h11, 0, 0, 0, "R2 first event");
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 0, 0, "R3 tick");
    cyc(0, 0, 0, 1, 0, "R7 read live");
    cyc(0, 0, 1, 1, 0, "R7 read live tick");
    // R5 event with tick
    cyc(1, 8'h22, 1, 0, 0, "R5 evt beats tick");
    // R8 overwrite: fill past capacity
    for (int i = 0; i < 10; i++) cyc(1, 8'h30 + i, 0, 0, 0, "R8 fill");
    // R12 read and event together at full
    cyc(1, 8'h55, 0, 1, 0, "R12 rd+evt");
    // R6 drain in order
    for (int i = 0; i < 9; i++) cyc(0, 0, 0, 1, 0, "R6 drain");
    // R4 count wrap and sticky overflow
    for (int i = 0; i < 131; i++) cyc(0, 0, 1, 0, 0, "R4 wrap");
    cyc(1, 8'h66, 0, 0, 0, "R4 rewrite");
    cyc(0, 0, 0, 1, 0, "R4 pop ovf entry");
    // R11 clear overrides everything
    cyc(1, 8'h77, 1, 1, 1, "R11 clear");
    cyc(0, 0, 1, 0, 0, "R11 after clear");

    // pseudo-random sweep over all input collisions
    for (int n = 0; n < 6000; n++) begin
      bit e, t, r, c;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      e = (lfsr[2:0] == 3'd0);
      t = lfsr[4];
      r = (lfsr[7:5] < 3'd2);
      c = (lfsr[15:8] == 8'd7);
      cyc(e, {lfsr[11:8], lfsr[3:0]}, t, r, c, "R12 sweep");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule